// File: doc/BRIEF.md
# Signed-Count Barrel Shift and Rotate Unit

This unit performs every shift and rotate operation of a 32-bit integer datapath. Each operation takes an operand, a shift-amount word, a 4-bit operation code and the current carry/test flag (T). It returns the shifted word and the new flag. There are two dynamic shifts, one arithmetic and one logical. For these, the sign of the amount word picks the direction: a non-negative count shifts left, and a negative count shifts right by its two's-complement magnitude taken from the low five bits. A negative count whose low five bits are all zero is a full-width right shift. The remaining codes are fixed-distance operations: single-bit shifts, single-bit rotates, rotates through the T flag, and logical shifts by 2, 8 and 16 places.

The datapath is combinational and ends in one register stage. A request presented with `in_valid` high is captured on the rising clock edge. The result and new flag appear on the outputs with `out_valid` high in the next cycle. Without a new request, the outputs hold their last values.

Top module: `shf_unit`

## Requirements
- R1: Dynamic arithmetic (code 0) and dynamic logical (code 1) with amount bit 31 clear shift the operand left by amount[4:0], filling with zeros.
- R2: Dynamic shifts with amount bit 31 set and amount[4:0] nonzero shift right by (~amount[4:0])+1 places. Code 0 fills with copies of bit 31 and code 1 fills with zeros.
- R3: Dynamic shifts with amount bit 31 set and amount[4:0] zero return 32 copies of operand bit 31 for code 0, and zero for code 1.
- R4: Both dynamic shifts return T unchanged.
- R5: Shift-left-one (code 2) fills bit 0 with 0 and rotate-left (code 5) moves old bit 31 into bit 0. Both put old bit 31 into T.
- R6: Shift-right-one (code 3) fills bit 31 with 0 and rotate-right (code 6) moves old bit 0 into bit 31. Both put old bit 0 into T.
- R7: Arithmetic shift-right-one (code 4) keeps bit 31 and puts old bit 0 into T.
- R8: Rotate-left through T (code 7) puts old T in bit 0 and old bit 31 in T. Rotate-right through T (code 8) puts old T in bit 31 and old bit 0 in T.
- R9: Fixed logical shifts by 2, 8 and 16 places fill with zeros and leave T unchanged. Left uses codes 9, 11 and 13; right uses codes 10, 12 and 14.
- R10: Code 15 returns the operand and T unchanged.
- R11: A request with `in_valid` high appears on `result` and `t_out` one cycle later with `out_valid` high. While `in_valid` is low, `out_valid` goes low and `result` and `t_out` keep their values.
- R12: While `rst_n` is low, `out_valid`, `result` and `t_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| operand | input | 32 | Value to shift |
| amount | input | 32 | Signed shift count for dynamic codes |
| t_in | input | 1 | Current T flag |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | Shifted value |
| t_out | output | 1 | New T flag |

## Verification
On every cycle, the assertions check the register-stage timing and the hold behaviour. They also check the T rules that relate one input bit to the output flag: fixed multi-bit shifts and dynamic shifts preserve T, single-bit left operations copy bit 31, and code 15 passes values through. Only the bench's scenarios show the full shifted values against an independent model. This covers the split between a negative count with zero low bits and a negative count with nonzero low bits, and the arithmetic versus logical fill for large right shifts. These are exercised by directed corners and by seeded random operands and counts.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_DYN_ARITH = 4'd0,
    OP_DYN_LOGIC = 4'd1,
    OP_SHL1      = 4'd2,
    OP_SHR1      = 4'd3,
    OP_SAR1      = 4'd4,
    OP_ROL1      = 4'd5,
    OP_ROR1      = 4'd6,
    OP_RCL1      = 4'd7,
    OP_RCR1      = 4'd8,
    OP_SHL2      = 4'd9,
    OP_SHR2      = 4'd10,
    OP_SHL8      = 4'd11,
    OP_SHR8      = 4'd12,
    OP_SHL16     = 4'd13,
    OP_SHR16     = 4'd14,
    OP_PASS      = 4'd15
  } shf_op_e;
endpackage

// File: rtl/shf_dyn.sv
// Signed-count shifter: sign of the count selects direction.
module shf_dyn #(
  parameter int unsigned W = 32,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic          arith_i,
  input  logic          neg_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [W-1:0]  data_i,
  output logic [W-1:0]  data_o
);
  logic [CW-1:0] rcnt;
  logic          zero_cnt;
  logic          fill;

  assign rcnt     = (~cnt_i) + 1'b1;
  assign zero_cnt = (cnt_i == '0);
  assign fill     = arith_i & data_i[W-1];

  always_comb begin
    if (!neg_i) begin
      data_o = data_i << cnt_i;
    end else if (zero_cnt) begin
      data_o = {W{fill}};
    end else if (arith_i) begin
      data_o = W'($signed(data_i) >>> rcnt);
    end else begin
      data_o = data_i >> rcnt;
    end
  end
endmodule

// File: rtl/shf_fixed.sv
// Fixed-distance shifts and rotates, with T handling.
module shf_fixed
  import shf_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    data_i,
  input  logic            t_i,
  output logic [W-1:0]    data_o,
  output logic            t_o
);
  logic msb, lsb;
  assign msb = data_i[W-1];
  assign lsb = data_i[0];

  always_comb begin
    data_o = data_i;
    t_o    = t_i;
    unique case (op_i)
      OP_SHL1:  begin data_o = {data_i[W-2:0], 1'b0}; t_o = msb; end
      OP_SHR1:  begin data_o = {1'b0, data_i[W-1:1]}; t_o = lsb; end
      OP_SAR1:  begin data_o = {msb, data_i[W-1:1]};  t_o = lsb; end
      OP_ROL1:  begin data_o = {data_i[W-2:0], msb};  t_o = msb; end
      OP_ROR1:  begin data_o = {lsb, data_i[W-1:1]};  t_o = lsb; end
      OP_RCL1:  begin data_o = {data_i[W-2:0], t_i};  t_o = msb; end
      OP_RCR1:  begin data_o = {t_i, data_i[W-1:1]};  t_o = lsb; end
      OP_SHL2:  data_o = data_i << 2;
      OP_SHR2:  data_o = data_i >> 2;
      OP_SHL8:  data_o = data_i << 8;
      OP_SHR8:  data_o = data_i >> 8;
      OP_SHL16: data_o = data_i << 16;
      OP_SHR16: data_o = data_i >> 16;
      default: begin
        data_o = data_i;
        t_o    = t_i;
      end
    endcase
  end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    operand,
  input  logic [W-1:0]    amount,
  input  logic            t_in,
  output logic            out_valid,
  output logic [W-1:0]    result,
  output logic            t_out
);
  logic [W-1:0] dyn_res, fix_res, res_d, res_q;
  logic         fix_t, t_d, t_q, vld_q;
  logic         is_dyn;

  assign is_dyn = (op == OP_DYN_ARITH) || (op == OP_DYN_LOGIC);

  shf_dyn #(.W(W)) u_dyn (
    .arith_i (op == OP_DYN_ARITH),
    .neg_i   (amount[W-1]),
    .cnt_i   (amount[CW-1:0]),
    .data_i  (operand),
    .data_o  (dyn_res)
  );

  shf_fixed #(.W(W)) u_fixed (
    .op_i   (op),
    .data_i (operand),
    .t_i    (t_in),
    .data_o (fix_res),
    .t_o    (fix_t)
  );

  always_comb begin
    res_d = is_dyn ? dyn_res : fix_res;
    t_d   = is_dyn ? t_in    : fix_t;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      t_q   <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= res_d;
        t_q   <= t_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign t_out     = t_q;

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r11_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(t_out)));
  a_r4_dyn_keeps_t: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_DYN_ARITH || op == OP_DYN_LOGIC)) |=> (t_out == $past(t_in)));
  a_r9_fixed_keeps_t: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op >= OP_SHL2 && op <= OP_SHR16) |=> (t_out == $past(t_in)));
  a_r5_left_t_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_SHL1 || op == OP_ROL1 || op == OP_RCL1)) |=> (t_out == $past(operand[W-1])));
  a_r10_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_PASS) |=> (result == $past(operand) && t_out == $past(t_in)));
  a_r1_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_DYN_ARITH || op == OP_DYN_LOGIC) && amount == '0) |=> (result == $past(operand)));
endmodule

// File: tb/shf_unit_tb.sv
`timescale 1ns/1ps
module shf_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [31:0] operand = 32'd0;
  logic [31:0] amount = 32'd0;
  logic        t_in = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        t_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  shf_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .operand(operand), .amount(amount), .t_in(t_in),
    .out_valid(out_valid), .result(result), .t_out(t_out)
  );

  function automatic string req_of(input logic [3:0] c, input logic [31:0] a);
    if (c <= 4'd1) begin
      if (!a[31]) return "R1";
      if (a[4:0] == 5'd0) return "R3";
      return "R2";
    end
    case (c)
      4'd2, 4'd5: return "R5";
      4'd3, 4'd6: return "R6";
      4'd4:       return "R7";
      4'd7, 4'd8: return "R8";
      4'd15:      return "R10";
      default:    return "R9";
    endcase
  endfunction

  // returns {t, value}
  function automatic logic [32:0] model(input logic [3:0] c, input logic [31:0] x,
                                        input logic [31:0] a, input logic t);
    int n;
    logic [31:0] r;
    logic nt;
    r = x; nt = t;
    case (c)
      4'd0, 4'd1: begin
        if (!a[31]) r = x << a[4:0];
        else begin
          n = 32 - int'(a[4:0]);
          if (n == 32) r = (c == 4'd0 && x[31]) ? 32'hFFFF_FFFF : 32'h0;
          else if (c == 4'd0) r = 32'($signed(x) >>> n);
          else r = x >> n;
        end
      end
      4'd2:  begin r = x << 1; nt = x[31]; end
      4'd3:  begin r = x >> 1; nt = x[0]; end
      4'd4:  begin r = 32'($signed(x) >>> 1); nt = x[0]; end
      4'd5:  begin r = (x << 1) | (x >> 31); nt = x[31]; end
      4'd6:  begin r = (x >> 1) | (x << 31); nt = x[0]; end
      4'd7:  begin r = (x << 1) | {31'd0, t}; nt = x[31]; end
      4'd8:  begin r = (x >> 1) | {t, 31'd0}; nt = x[0]; end
      4'd9:  r = x << 2;
      4'd10: r = x >> 2;
      4'd11: r = x << 8;
      4'd12: r = x >> 8;
      4'd13: r = x << 16;
      4'd14: r = x >> 16;
      default: ;
    endcase
    return {nt, r};
  endfunction

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual vld/t/res=%0b/%0b/%08h expected %0b/%0b/%08h",
               req, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic run_op(input logic [3:0] c, input logic [31:0] x,
                        input logic [31:0] a, input logic t);
    logic [32:0] e;
    @(negedge clk);
    in_valid = 1'b1; op = c; operand = x; amount = a; t_in = t;
    e = model(c, x, a, t);
    @(negedge clk);
    check(req_of(c, a), {out_valid, t_out, result}, {1'b1, e});
    check("R11", {33'd0, out_valid}, {33'd0, 1'b1});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    logic        held_t;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R12", {out_valid, t_out, result}, 34'd0);
    rst_n = 1'b1;

    // directed corners
    run_op(4'd0, 32'h8000_1234, 32'h8000_0000, 1'b0); // R3 sign fill
    run_op(4'd1, 32'h8000_1234, 32'h8000_0000, 1'b1); // R3 zero
    run_op(4'd0, 32'h7000_0000, 32'hFFFF_FFE0, 1'b0); // R3 positive
    run_op(4'd0, 32'hF000_000F, 32'hFFFF_FFFF, 1'b1); // R2 by 1
    run_op(4'd1, 32'hF000_000F, 32'hFFFF_FFFF, 1'b0); // R2 by 1
    run_op(4'd0, 32'h8000_0000, 32'h8000_0001, 1'b0); // R2 by 31
    run_op(4'd1, 32'h8000_0000, 32'h8000_0001, 1'b0); // R2 by 31
    run_op(4'd1, 32'h0000_0001, 32'h0000_001F, 1'b1); // R1 by 31, R4
    run_op(4'd0, 32'hDEAD_BEEF, 32'h0000_0000, 1'b1); // R1 by 0
    run_op(4'd1, 32'h0000_0003, 32'h7FFF_FFE4, 1'b0); // R1 low bits only
    run_op(4'd7, 32'h8000_0000, 32'h0, 1'b1);         // R8
    run_op(4'd8, 32'h0000_0001, 32'h0, 1'b1);         // R8
    run_op(4'd4, 32'h8000_0001, 32'h0, 1'b0);         // R7
    run_op(4'd5, 32'h8000_0000, 32'h0, 1'b0);         // R5
    run_op(4'd6, 32'h0000_0001, 32'h0, 1'b0);         // R6
    run_op(4'd13, 32'h1234_5678, 32'h0, 1'b1);        // R9
    run_op(4'd14, 32'h1234_5678, 32'h0, 1'b0);        // R9
    run_op(4'd15, 32'hCAFE_F00D, 32'h8000_0000, 1'b1); // R10

    // R11: hold while idle, changed inputs must not reach outputs
    held = result; held_t = t_out;
    @(negedge clk);
    in_valid = 1'b0; op = 4'd2; operand = 32'hFFFF_FFFF; t_in = 1'b0;
    repeat (2) @(negedge clk);
    check("R11", {out_valid, t_out, result}, {1'b0, held_t, held});

    // seeded random
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] a;
      a = $urandom();
      if (i % 5 == 0) a = {a[31], 26'd0, a[4:0]};
      run_op(4'($urandom_range(0, 15)), $urandom(), a, 1'($urandom()));
    end

    // R12: reset mid-stream clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R12", {out_valid, t_out, result}, 34'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule